// File: doc/BRIEF.md
# Tick-Aware Instruction Prefetch Controller

This block sits between a processor's instruction fetch and main memory. It serves a program built from synchronous threads that all pause at a common tick boundary. Software fills a small command table before the program runs. Each table entry pairs an activating program-counter value with an action. Every accepted fetch address is compared with the table. When an address matches exactly, the action of that entry runs right after the instruction has been returned.

The actions keep two structures up to date. The first is a FIFO of thread resumption addresses. The second is a one-line thread-switch buffer, preloaded with the instructions found at the next thread's resumption address. A jump to the next thread then finds its first line already on chip, so a context switch costs no more than straight-line code. A spawn action reads a line of resumption addresses from memory into an operand line and pushes some or all of them. A tick-end action requeues the running thread and stages the next one. A terminate action stages the next thread without requeuing the running one.

Fetches use a valid/ready handshake. The block lowers `req_ready` from the accepting edge until the instruction has been delivered and the triggered action has finished. The response is a one-cycle `out_valid` pulse that the consumer must take; it cannot be stalled. Main memory is reached through a line-read request with valid/ready. It answers with exactly four data beats in word order. `mem_rsp_valid` may have gaps between beats but has no back-pressure.

Top module: `tick_fetch_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `q_empty` is 1, `q_full` is 0, `out_valid` and `mem_req_valid` are 0, and the switch buffer is invalid, so the first fetch is a miss.
- R2: A fetch whose address is outside the valid switch-buffer line issues one memory request at the line-aligned address (low 4 bits zero). It waits for the four beats and returns the word selected by address bits [3:2], with `out_hit` = 0.
- R3: A fetch whose address bits [15:4] equal the valid buffer line returns the buffered word selected by bits [3:2]. `out_hit` is 1, and the fetch makes no memory request of its own.
- R4: An action runs only when the fetch address equals an entry's activating address in all 16 bits. When several entries match, the one with the lowest index wins. Entries whose type is code 0 are empty.
- R5: Spawn (type code 1) reads the memory line at the operand's line address. It then pushes the low 16 bits of words 0 to `cnt` of that line into the queue, in word order.
- R6: Tick-end (type code 2) pushes the operand as the running thread's resumption address and pops the head. It then loads the buffer with the line holding the popped address. With an empty queue, the operand address itself is staged and the queue stays empty.
- R7: Terminate (type code 3) pops the head and loads the buffer with its line, with no push. With an empty queue it only invalidates the buffer.
- R8: The queue returns resumption addresses in first-in first-out order, holds 8 entries, and reports `q_full` and `q_empty`.
- R9: A spawn push while the queue is full is dropped, and `q_err` pulses for one cycle per dropped address. A tick-end on a full queue loses nothing.
- R10: `req_ready` stays low from acceptance until the triggered action has finished. A pending memory request holds its address until accepted.
- R11: A table write takes effect for fetches accepted after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch address offered |
| req_ready | output | 1 | Controller can accept a fetch |
| req_pc | input | 16 | Fetch byte address |
| out_valid | output | 1 | One-cycle instruction delivery |
| out_instr | output | 32 | Delivered instruction |
| out_hit | output | 1 | Instruction came from the switch buffer |
| tbl_we | input | 1 | Command table write strobe |
| tbl_idx | input | 3 | Entry index to write |
| tbl_cmd | input | 2 | Action type: 0 empty, 1 spawn, 2 tick-end, 3 terminate |
| tbl_cnt | input | 2 | Spawn count minus one |
| tbl_addr | input | 16 | Activating fetch address |
| tbl_opnd | input | 16 | Operand: line address or resumption address |
| mem_req_valid | output | 1 | Line read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 16 | Line-aligned read address |
| mem_rsp_valid | input | 1 | Data beat present |
| mem_rsp_data | input | 32 | Data beat, word order within the line |
| q_full | output | 1 | Resumption queue full |
| q_empty | output | 1 | Resumption queue empty |
| q_err | output | 1 | Pulse per dropped push |

## Verification
The sharpest coincidence is the tick-end action on a full queue, where one push and one pop land in the same cycle. It is provoked by filling the queue with two four-address spawns, then hitting a tick-end entry. The run is judged by the flags staying full, no `q_err` pulse, and a buffer hit on the head address. A second overlap is a fetch that is both a buffer hit and an action trigger. There the hit flag and the memory-request count show that the instruction came from the old line before the line was replaced. Random table contents and random fetch addresses then mix both cases against a queue and buffer model.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_SPAWN = 2'd1,
    CMD_TICK  = 2'd2,
    CMD_TERM  = 2'd3
  } cmd_e;
endpackage

// File: rtl/tfc_cmd_table.sv
module tfc_cmd_table
  import tfc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NENT = 8,
  parameter int CW   = 2,
  localparam int IW  = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  cmd_e          wcmd,
  input  logic [CW-1:0] wcnt,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] wopnd,
  input  logic [AW-1:0] pc,
  output cmd_e          m_cmd,
  output logic [CW-1:0] m_cnt,
  output logic [AW-1:0] m_opnd
);
  cmd_e          ent_cmd  [NENT];
  logic [CW-1:0] ent_cnt  [NENT];
  logic [AW-1:0] ent_addr [NENT];
  logic [AW-1:0] ent_opnd [NENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        ent_cmd[i]  <= CMD_NONE;
        ent_cnt[i]  <= '0;
        ent_addr[i] <= '0;
        ent_opnd[i] <= '0;
      end
    end else if (we) begin
      ent_cmd[widx]  <= wcmd;
      ent_cnt[widx]  <= wcnt;
      ent_addr[widx] <= waddr;
      ent_opnd[widx] <= wopnd;
    end
  end

  // scan from the top so the lowest matching index is the last to assign
  always_comb begin
    m_cmd  = CMD_NONE;
    m_cnt  = '0;
    m_opnd = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (ent_cmd[i] != CMD_NONE && ent_addr[i] == pc) begin
        m_cmd  = ent_cmd[i];
        m_cnt  = ent_cnt[i];
        m_opnd = ent_opnd[i];
      end
    end
  end
endmodule

// File: rtl/tfc_addr_queue.sv
module tfc_addr_queue #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] dout,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (PW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = slot[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop) cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot[wp] <= din;
  end
endmodule

// File: rtl/tfc_line_fetch.sv
module tfc_line_fetch #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int WPL  = 4,
  localparam int CW  = $clog2(WPL),
  localparam int OFS = $clog2(DW/8) + CW,
  localparam int LW  = AW - OFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [LW-1:0] line,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          beat_we,
  output logic [CW-1:0] beat_idx,
  output logic [DW-1:0] beat_data,
  output logic          done
);
  logic          req_q, dat_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;

  assign mem_req_valid = req_q;
  assign mem_req_addr  = addr_q;
  assign beat_we       = dat_q && mem_rsp_valid;
  assign beat_idx      = cnt_q;
  assign beat_data     = mem_rsp_data;
  assign done          = beat_we && (cnt_q == CW'(WPL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      dat_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (go) begin
      req_q  <= 1'b1;
      addr_q <= {line, {OFS{1'b0}}};
    end else if (req_q && mem_req_ready) begin
      req_q <= 1'b0;
      dat_q <= 1'b1;
      cnt_q <= '0;
    end else if (beat_we) begin
      cnt_q <= cnt_q + 1'b1;
      if (done) dat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_fetch_ctrl.sv
module tick_fetch_ctrl
  import tfc_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int WPL    = 4,
  parameter int NENT   = 8,
  parameter int QDEPTH = 8,
  localparam int IW    = $clog2(NENT),
  localparam int CW    = $clog2(WPL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_pc,
  output logic          out_valid,
  output logic [DW-1:0] out_instr,
  output logic          out_hit,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  logic [1:0]    tbl_cmd,
  input  logic [CW-1:0] tbl_cnt,
  input  logic [AW-1:0] tbl_addr,
  input  logic [AW-1:0] tbl_opnd,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          q_full,
  output logic          q_empty,
  output logic          q_err
);
  localparam int BW  = $clog2(DW/8);
  localparam int OFS = BW + CW;
  localparam int LW  = AW - OFS;

  typedef enum logic [2:0] {S_IDLE, S_INSTR, S_CMD, S_TIB, S_OPB, S_PUSH} st_e;

  st_e           st;
  cmd_e          cmd_q, m_cmd;
  logic [CW-1:0] cnt_q, m_cnt, widx_q, pidx;
  logic [AW-1:0] opnd_q, m_opnd;
  logic [DW-1:0] tib_q [WPL];
  logic [AW-1:0] opb_q [WPL];
  logic          tib_v;
  logic [LW-1:0] tib_line;
  logic          accept, req_hit;

  logic          q_push, q_pop;
  logic [AW-1:0] q_din, q_dout;
  logic          f_go, b_we, f_done;
  logic [LW-1:0] f_line;
  logic [CW-1:0] b_idx;
  logic [DW-1:0] b_data;
  logic          unused_lo;

  assign unused_lo = ^q_dout[OFS-1:0];
  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_hit   = tib_v && (req_pc[AW-1:OFS] == tib_line);

  tfc_cmd_table #(.AW(AW), .NENT(NENT), .CW(CW)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx),
    .wcmd(cmd_e'(tbl_cmd)), .wcnt(tbl_cnt), .waddr(tbl_addr), .wopnd(tbl_opnd),
    .pc(req_pc), .m_cmd(m_cmd), .m_cnt(m_cnt), .m_opnd(m_opnd)
  );

  tfc_addr_queue #(.AW(AW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .pop(q_pop), .din(q_din),
    .dout(q_dout), .full(q_full), .empty(q_empty)
  );

  tfc_line_fetch #(.AW(AW), .DW(DW), .WPL(WPL)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(f_go), .line(f_line),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .beat_we(b_we), .beat_idx(b_idx),
    .beat_data(b_data), .done(f_done)
  );

  always_comb begin
    f_go   = 1'b0;
    f_line = req_pc[AW-1:OFS];
    q_push = 1'b0;
    q_pop  = 1'b0;
    q_din  = opnd_q;
    case (st)
      S_IDLE: f_go = accept && !req_hit;
      S_CMD: begin
        case (cmd_q)
          CMD_SPAWN: begin
            f_go   = 1'b1;
            f_line = opnd_q[AW-1:OFS];
          end
          CMD_TICK: begin
            f_go = 1'b1;
            if (q_empty) f_line = opnd_q[AW-1:OFS];
            else begin
              f_line = q_dout[AW-1:OFS];
              q_push = 1'b1;
              q_pop  = 1'b1;
            end
          end
          CMD_TERM: begin
            if (!q_empty) begin
              f_go   = 1'b1;
              f_line = q_dout[AW-1:OFS];
              q_pop  = 1'b1;
            end
          end
          default: ;
        endcase
      end
      S_PUSH: begin
        q_push = 1'b1;
        q_din  = opb_q[pidx];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd_q     <= CMD_NONE;
      cnt_q     <= '0;
      opnd_q    <= '0;
      widx_q    <= '0;
      pidx      <= '0;
      tib_v     <= 1'b0;
      tib_line  <= '0;
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_instr <= '0;
      q_err     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      q_err     <= (st == S_PUSH) && q_full;
      case (st)
        S_IDLE: if (accept) begin
          cmd_q  <= m_cmd;
          cnt_q  <= m_cnt;
          opnd_q <= m_opnd;
          widx_q <= req_pc[OFS-1:BW];
          if (req_hit) begin
            out_valid <= 1'b1;
            out_hit   <= 1'b1;
            out_instr <= tib_q[req_pc[OFS-1:BW]];
            st        <= S_CMD;
          end else begin
            st <= S_INSTR;
          end
        end
        S_INSTR: begin
          if (b_we && b_idx == widx_q) out_instr <= b_data;
          if (f_done) begin
            out_valid <= 1'b1;
            st        <= S_CMD;
          end
        end
        S_CMD: begin
          case (cmd_q)
            CMD_SPAWN: st <= S_OPB;
            CMD_TICK: begin
              tib_v    <= 1'b0;
              tib_line <= f_line;
              st       <= S_TIB;
            end
            CMD_TERM: begin
              tib_v <= 1'b0;
              if (!q_empty) begin
                tib_line <= f_line;
                st       <= S_TIB;
              end else begin
                st <= S_IDLE;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
        S_TIB: if (f_done) begin
          tib_v <= 1'b1;
          st    <= S_IDLE;
        end
        S_OPB: if (f_done) begin
          pidx <= '0;
          st   <= S_PUSH;
        end
        S_PUSH: begin
          if (pidx == cnt_q) st <= S_IDLE;
          else pidx <= pidx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (b_we && st == S_TIB) tib_q[b_idx] <= b_data;
    if (b_we && st == S_OPB) opb_q[b_idx] <= b_data[AW-1:0];
  end
endmodule

// File: rtl/tick_fetch_ctrl_chk.sv
module tick_fetch_ctrl_chk #(
  parameter int AW  = 16,
  parameter int OFS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          out_valid,
  input logic          out_hit,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          q_full,
  input logic          q_empty,
  input logic          q_err
);
  // R3
  hit_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  // R9
  err_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_err |-> $past(q_full));

  // R10
  busy_at_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  busy_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R2
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFS-1:0] == '0));
endmodule

bind tick_fetch_ctrl tick_fetch_ctrl_chk #(.AW(AW), .OFS(OFS)) u_chk (.*);

// File: tb/tick_fetch_ctrl_bench.sv
module tick_fetch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_pc = '0;
  logic        out_valid;
  logic [31:0] out_instr;
  logic        out_hit;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [1:0]  tbl_cmd = '0;
  logic [1:0]  tbl_cnt = '0;
  logic [15:0] tbl_addr = '0;
  logic [15:0] tbl_opnd = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        q_full, q_empty, q_err;

  always #10 clk = ~clk;

  tick_fetch_ctrl u_tick_fetch_ctrl (.*);

  int n_chk = 0, n_fail = 0, n_memreq = 0, n_err_seen = 0, n_err_exp = 0;

  // model state
  logic [1:0]  t_cmd [8];
  logic [1:0]  t_cnt [8];
  logic [15:0] t_addr [8];
  logic [15:0] t_opnd [8];
  logic [15:0] mq[$];
  logic        m_tibv = 1'b0;
  logic [11:0] m_tibl = '0;
  logic [15:0] m_last = '0;

  function automatic logic [31:0] memw(input logic [15:0] a);
    return {16'hC3A5 ^ a, 8'h00, {a[3:0], a[7:4]} ^ 8'h6C};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: decisions made at negedge, sampled at the next posedge
  initial begin
    int left = 0;
    logic [15:0] base = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (left > 0) begin
        if ($urandom % 4 != 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memw(base + 16'(4 * (4 - left)));
          left--;
        end
      end else begin
        mem_req_ready = ($urandom % 3 != 0);
        if (rst_n && mem_req_valid && mem_req_ready) begin
          base = mem_req_addr;
          left = 4;
          n_memreq++;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && q_err) n_err_seen++;

  task automatic twrite(input int idx, input logic [1:0] c, input logic [1:0] n,
                        input logic [15:0] a, input logic [15:0] o);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_cmd = c; tbl_cnt = n; tbl_addr = a; tbl_opnd = o;
    @(negedge clk);
    tbl_we = 1'b0;
    t_cmd[idx] = c; t_cnt[idx] = n; t_addr[idx] = a; t_opnd[idx] = o;
  endtask

  task automatic fetch(input logic [15:0] pc, input string tag);
    int mi = -1;
    int base_req = n_memreq;
    int exp_req;
    logic ehit;
    logic [15:0] nxt;
    for (int i = 0; i < 8; i++)
      if (mi < 0 && t_cmd[i] != 2'd0 && t_addr[i] == pc) mi = i;
    ehit = m_tibv && (pc[15:4] == m_tibl);
    exp_req = ehit ? 0 : 1;
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    chk(ehit ? "R3 instr" : "R2 instr", out_instr, memw({pc[15:2], 2'b00}));
    chk({tag, " hit"}, 32'(out_hit), 32'(ehit));
    if (mi >= 0) begin
      case (t_cmd[mi])
        2'd1: begin
          exp_req++;
          for (int k = 0; k <= int'(t_cnt[mi]); k++) begin
            nxt = memw({t_opnd[mi][15:4], 4'h0} + 16'(4 * k))[15:0];
            if (mq.size() < 8) mq.push_back(nxt);
            else n_err_exp++;
          end
        end
        2'd2: begin
          exp_req++;
          if (mq.size() == 0) nxt = t_opnd[mi];
          else begin nxt = mq.pop_front(); mq.push_back(t_opnd[mi]); end
          m_tibv = 1'b1; m_tibl = nxt[15:4]; m_last = nxt;
        end
        default: begin
          if (mq.size() == 0) m_tibv = 1'b0;
          else begin
            exp_req++;
            nxt = mq.pop_front();
            m_tibv = 1'b1; m_tibl = nxt[15:4]; m_last = nxt;
          end
        end
      endcase
    end
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk({tag, " memreq"}, 32'(n_memreq - base_req), 32'(exp_req));
    chk("R8 full", 32'(q_full), 32'(mq.size() == 8));
    chk("R8 empty", 32'(q_empty), 32'(mq.size() == 0));
    chk("R9 dropped", 32'(n_err_seen), 32'(n_err_exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      t_cmd[i] = 0; t_cnt[i] = 0; t_addr[i] = 0; t_opnd[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 empty", 32'(q_empty), 1);
    chk("R1 full", 32'(q_full), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 mem_req", 32'(mem_req_valid), 0);
    fetch(16'h0040, "R1 first miss");

    // R5 spawn four, twice: queue fills (R8)
    twrite(0, 2'd1, 2'd3, 16'h0100, 16'h0800);
    twrite(1, 2'd1, 2'd3, 16'h0110, 16'h0900);
    fetch(16'h0100, "R5 spawn");
    fetch(16'h0110, "R5 spawn full");
    // R9 spawn on full queue drops both
    twrite(2, 2'd1, 2'd1, 16'h0120, 16'h0A00);
    fetch(16'h0120, "R9 drop");
    // R6 tick-end on full queue: push and pop together
    twrite(3, 2'd2, 2'd0, 16'h0130, 16'h0040);
    fetch(16'h0130, "R6 tick full");
    fetch(m_last, "R6 staged hit");
    fetch(m_last ^ 16'h0004, "R3 other word");
    // R7 terminate drains in order (R8)
    twrite(4, 2'd3, 2'd0, 16'h0140, 16'h0000);
    for (int i = 0; i < 9; i++) begin
      fetch(16'h0140, "R7 term");
      if (m_tibv) fetch(m_last, "R8 order hit");
    end
    fetch(m_last, "R7 invalidated miss");
    // R6 tick-end on empty queue stages its own operand
    fetch(16'h0130, "R6 tick empty");
    fetch(16'h0048, "R6 own line hit");
    // R4 near miss and priority
    fetch(16'h0132, "R4 near miss");
    twrite(6, 2'd3, 2'd0, 16'h0150, 16'h0000);
    twrite(2, 2'd1, 2'd0, 16'h0150, 16'h0A00);
    fetch(16'h0150, "R4 lowest index");
    // R11 write then use
    fetch(16'h0160, "R11 before write");
    twrite(7, 2'd1, 2'd0, 16'h0160, 16'h0B00);
    fetch(16'h0160, "R11 after write");

    // random phase
    for (int i = 0; i < 8; i++)
      twrite(i, 2'($urandom % 4), 2'($urandom % 4), 16'($urandom % 64) << 2,
             16'($urandom % 256));
    for (int n = 0; n < 400; n++) begin
      if (n % 100 == 99)
        twrite(int'($urandom % 8), 2'($urandom % 4), 2'($urandom % 4),
               16'($urandom % 64) << 2, 16'($urandom % 256));
      if (m_tibv && $urandom % 3 == 0) fetch(m_last, "R3 random");
      else fetch(16'($urandom % 256), "R4 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule